// File: doc/BRIEF.md
# Bus-Cycle Request Assembler

This block gathers, over a 16-bit host register bus, everything needed to describe one cycle on a wide target bus. It then hands that description to a bus-cycle engine that runs on its own clock. The host starts a request by writing a command word that names the cycle type. The block keeps that type and works out from it how many information words must follow. It stores each of those words in a staging buffer. When the last expected word arrives, it launches the request.

The launch crosses into the target clock domain through a four-phase level handshake. A request level is synchronized into the target domain. The engine's acknowledge is synchronized back. The request falls only after the acknowledge has been seen, and a new request can start only after the acknowledge has fallen again. Data returned by the engine is captured in the host domain when the acknowledge arrives, and it stays there for the host to read. A busy flag and a sticky error flag give the host the status of the transaction.

Top module: `cycreq_assembler`

## Requirements
- R1: After reset, `busy`, `err` and `t_req` are low and `rsp_data` is zero.
- R2: A host write with `wr_sel`=0 is a command word, and its bits 1:0 select the cycle type: 0 read, 1 write, 2 interrupt acknowledge, 3 locked read. The type is held and driven on `t_type` for the whole transaction.
- R3: The number of information words (`wr_sel`=1) expected after a command depends on its type. Read and locked read expect 3 words, write expects 7, and interrupt acknowledge expects 0, so it launches at once. The words are taken in this order: address bits 15:0, address bits 31:16, control word (byte enables in bits 7:0), then for writes data bits 15:0, 31:16, 47:32 and 63:48.
- R4: The request is not launched (neither `busy` nor `t_req` rises) until the expected number of information words has been written.
- R5: While the request is raised, `t_type`, `t_addr`, `t_ctl` and `t_wdata` carry the assembled values and stay stable. The staging buffer is cleared when a command is accepted, so `t_wdata` is zero for every type other than write.
- R6: An information word written while no command is collecting (idle or busy) is ignored and does not change any field of the current or the next request.
- R7: A command word written while a previous request is still collecting or outstanding is rejected and sets `err`. The `err` flag stays set until the host writes with `wr_sel`=2 or reset is applied.
- R8: `busy` is low while words are being collected. It rises in the cycle after the launching write and stays high until the returned acknowledge has been seen and has fallen again.
- R9: `rsp_data` takes the value of `t_rdata` when the synchronized acknowledge is seen, and it holds that value until the next capture.
- R10: The host-side request falls only after the synchronized acknowledge is high, and it rises only while that acknowledge is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host clock |
| hrst_n | input | 1 | Host-domain reset, active low |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Write target: 0 command, 1 information word, 2 clear error |
| wr_data | input | HW | Host write data |
| busy | output | 1 | Transaction launched and not yet complete |
| err | output | 1 | Sticky rejected-command flag |
| rsp_data | output | DW | Data captured from the engine |
| tclk | input | 1 | Target clock |
| trst_n | input | 1 | Target-domain reset, active low |
| t_req | output | 1 | Request level, synchronized to `tclk` |
| t_type | output | 2 | Cycle type of the request |
| t_addr | output | AW | Assembled address |
| t_ctl | output | HW | Control word, byte enables in bits 7:0 |
| t_wdata | output | DW | Assembled write data |
| t_ack | input | 1 | Engine acknowledge, in the `tclk` domain |
| t_rdata | input | DW | Engine return data, stable while `t_ack` is high |

## Verification
The capture of returned data and the rejection of a new command can fall in the same host cycle. The bench provokes this by holding a command write on the bus for every cycle of a long transaction, so one of those writes lands on the capture edge. The result is judged correct if `err` is set, `rsp_data` still equals the value the engine model returned, and no further request is launched once `busy` falls. A second overlap, an information word written while the request is outstanding, is judged by the scoreboard comparing the fields at acknowledge time.

// File: rtl/cra_pkg.sv
package cra_pkg;
    typedef enum logic [1:0] {
        CY_READ  = 2'd0,
        CY_WRITE = 2'd1,
        CY_INTA  = 2'd2,
        CY_LREAD = 2'd3
    } cyc_e;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_INFO = 2'd1,
        SEL_CLR  = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_WAIT_ACK,
        ST_WAIT_DROP
    } st_e;
endpackage

// File: rtl/cra_sync.sv
module cra_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/cra_host_ctrl.sv
module cra_host_ctrl
    import cra_pkg::*;
#(
    parameter int HW = 16,
    parameter int AW = 32,
    parameter int DW = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [1:0]                     wr_sel,
    input  logic [HW-1:0]                  wr_data,
    input  logic                           ack_s,
    input  logic [DW-1:0]                  rdata_in,
    output logic                           req,
    output logic                           busy,
    output logic                           err,
    output logic [1:0]                     typ,
    output logic [(AW/HW+1+DW/HW)*HW-1:0]  stg,
    output logic [DW-1:0]                  rsp
);
    localparam int AWORDS = AW / HW;
    localparam int DWORDS = DW / HW;
    localparam int NSTG   = AWORDS + 1 + DWORDS;
    localparam int CW     = $clog2(NSTG + 1);

    typedef struct packed {
        st_e               st;
        logic [1:0]        typ;
        logic [CW-1:0]     cnt;
        logic [CW-1:0]     need;
        logic [NSTG*HW-1:0] stg;
        logic              req;
        logic              err;
        logic [DW-1:0]     rsp;
    } regs_t;

    regs_t r_d, r_q;

    function automatic logic [CW-1:0] words_for(input logic [1:0] t);
        case (cyc_e'(t))
            CY_WRITE: words_for = CW'(NSTG);
            CY_INTA:  words_for = '0;
            default:  words_for = CW'(AWORDS + 1);
        endcase
    endfunction

    logic cmd_wr, info_wr, clr_wr;
    assign cmd_wr  = wr_en && (sel_e'(wr_sel) == SEL_CMD);
    assign info_wr = wr_en && (sel_e'(wr_sel) == SEL_INFO);
    assign clr_wr  = wr_en && (sel_e'(wr_sel) == SEL_CLR);

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (cmd_wr) begin
                    r_d.typ  = wr_data[1:0];
                    r_d.stg  = '0;
                    r_d.cnt  = '0;
                    r_d.need = words_for(wr_data[1:0]);
                    if (words_for(wr_data[1:0]) == '0) begin
                        r_d.st  = ST_WAIT_ACK;
                        r_d.req = 1'b1;
                    end else begin
                        r_d.st  = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                if (info_wr) begin
                    r_d.stg[int'(r_q.cnt)*HW +: HW] = wr_data;
                    r_d.cnt = r_q.cnt + CW'(1);
                    if (r_q.cnt == r_q.need - CW'(1)) begin
                        r_d.st  = ST_WAIT_ACK;
                        r_d.req = 1'b1;
                    end
                end
            end
            ST_WAIT_ACK: begin
                if (ack_s) begin
                    r_d.rsp = rdata_in;
                    r_d.req = 1'b0;
                    r_d.st  = ST_WAIT_DROP;
                end
            end
            default: begin
                if (!ack_s) r_d.st = ST_IDLE;
            end
        endcase
        if (cmd_wr && r_q.st != ST_IDLE) r_d.err = 1'b1;
        if (clr_wr)                      r_d.err = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req  = r_q.req;
    assign busy = (r_q.st == ST_WAIT_ACK) || (r_q.st == ST_WAIT_DROP);
    assign err  = r_q.err;
    assign typ  = r_q.typ;
    assign stg  = r_q.stg;
    assign rsp  = r_q.rsp;
endmodule

// File: rtl/cycreq_assembler.sv
module cycreq_assembler #(
    parameter int HW   = 16,
    parameter int AW   = 32,
    parameter int DW   = 64,
    parameter int SYNC = 2
) (
    input  logic          hclk,
    input  logic          hrst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [HW-1:0] wr_data,
    output logic          busy,
    output logic          err,
    output logic [DW-1:0] rsp_data,
    input  logic          tclk,
    input  logic          trst_n,
    output logic          t_req,
    output logic [1:0]    t_type,
    output logic [AW-1:0] t_addr,
    output logic [HW-1:0] t_ctl,
    output logic [DW-1:0] t_wdata,
    input  logic          t_ack,
    input  logic [DW-1:0] t_rdata
);
    localparam int NSTG = AW / HW + 1 + DW / HW;

    logic                 req_h;
    logic                 ack_h;
    logic [NSTG*HW-1:0]   stg;

    cra_host_ctrl #(.HW(HW), .AW(AW), .DW(DW)) u_ctrl (
        .clk      (hclk),
        .rst_n    (hrst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .ack_s    (ack_h),
        .rdata_in (t_rdata),
        .req      (req_h),
        .busy     (busy),
        .err      (err),
        .typ      (t_type),
        .stg      (stg),
        .rsp      (rsp_data)
    );

    cra_sync #(.STAGES(SYNC)) u_req_sync (
        .clk   (tclk),
        .rst_n (trst_n),
        .d     (req_h),
        .q     (t_req)
    );

    cra_sync #(.STAGES(SYNC)) u_ack_sync (
        .clk   (hclk),
        .rst_n (hrst_n),
        .d     (t_ack),
        .q     (ack_h)
    );

    assign t_addr  = stg[AW-1:0];
    assign t_ctl   = stg[AW +: HW];
    assign t_wdata = stg[AW+HW +: DW];
endmodule

// File: rtl/cra_checker.sv
module cra_checker #(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input logic          hclk,
    input logic          hrst_n,
    input logic          wr_en,
    input logic [1:0]    wr_sel,
    input logic          busy,
    input logic          err,
    input logic          req_h,
    input logic          ack_h,
    input logic [DW-1:0] rsp_data,
    input logic [AW-1:0] t_addr,
    input logic [DW-1:0] t_wdata
);
    p_req_drop_after_ack_r10: assert property (@(posedge hclk) disable iff (!hrst_n)
        $fell(req_h) |-> ack_h);

    p_req_rise_ack_low_r10: assert property (@(posedge hclk) disable iff (!hrst_n)
        $rose(req_h) |-> !ack_h);

    p_busy_covers_req_r8: assert property (@(posedge hclk) disable iff (!hrst_n)
        req_h |-> busy);

    p_err_sticky_r7: assert property (@(posedge hclk) disable iff (!hrst_n)
        (err && !(wr_en && wr_sel == 2'd2)) |=> err);

    p_err_from_cmd_r7: assert property (@(posedge hclk) disable iff (!hrst_n)
        $rose(err) |-> ($past(wr_en) && $past(wr_sel) == 2'd0 && $past(busy || req_h || !$stable(t_addr) || 1'b1)));

    p_rsp_capture_r9: assert property (@(posedge hclk) disable iff (!hrst_n)
        !$stable(rsp_data) |-> ($past(ack_h) && $past(req_h)));

    p_fields_stable_r5: assert property (@(posedge hclk) disable iff (!hrst_n)
        (req_h && $past(req_h)) |-> ($stable(t_addr) && $stable(t_wdata)));
endmodule

bind cycreq_assembler cra_checker #(.AW(AW), .DW(DW)) u_chk (
    .hclk     (hclk),
    .hrst_n   (hrst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .busy     (busy),
    .err      (err),
    .req_h    (req_h),
    .ack_h    (ack_h),
    .rsp_data (rsp_data),
    .t_addr   (t_addr),
    .t_wdata  (t_wdata)
);

// File: tb/cycreq_assembler_test.sv
module cycreq_assembler_test;
    localparam int HPER = 10;
    localparam int TPER = 14;

    logic        hclk = 0, tclk = 0;
    logic        hrst_n = 0, trst_n = 0;
    logic        wr_en = 0;
    logic [1:0]  wr_sel = 0;
    logic [15:0] wr_data = 0;
    logic        busy, err, t_req;
    logic [63:0] rsp_data, t_wdata;
    logic [1:0]  t_type;
    logic [31:0] t_addr;
    logic [15:0] t_ctl;
    logic        t_ack = 0;
    logic [63:0] t_rdata = 0;

    int checks = 0, errors = 0;
    int eng_delay = 2;
    int launches = 0;

    typedef struct packed {
        logic [1:0]  typ;
        logic [31:0] addr;
        logic [15:0] ctl;
        logic [63:0] wdata;
    } item_t;
    item_t exp_q[$];

    always #(HPER/2) hclk = ~hclk;
    always #(TPER/2) tclk = ~tclk;

    cycreq_assembler uut (
        .hclk(hclk), .hrst_n(hrst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .busy(busy), .err(err), .rsp_data(rsp_data), .tclk(tclk), .trst_n(trst_n),
        .t_req(t_req), .t_type(t_type), .t_addr(t_addr), .t_ctl(t_ctl), .t_wdata(t_wdata),
        .t_ack(t_ack), .t_rdata(t_rdata)
    );

    function automatic logic [63:0] rd_model(input logic [31:0] a);
        return {a ^ 32'h5A5A_A5A5, a};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge hclk);
        wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge hclk);
        wr_en = 0; wr_sel = 2'd3;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (busy && n < 3000) begin
            @(negedge hclk);
            n++;
        end
        chk(!busy, req, 64'(busy), 64'd0);
    endtask

    // driver: pushes expectation, writes command and all words
    task automatic send(input logic [1:0] typ, input logic [31:0] a, input logic [15:0] c, input logic [63:0] wd);
        item_t it;
        it.typ = typ; it.addr = (typ == 2'd2) ? 32'd0 : a;
        it.ctl = (typ == 2'd2) ? 16'd0 : c;
        it.wdata = (typ == 2'd1) ? wd : 64'd0;
        exp_q.push_back(it);
        host_wr(2'd0, {14'd0, typ});
        if (typ != 2'd2) begin
            host_wr(2'd1, a[15:0]);
            host_wr(2'd1, a[31:16]);
            host_wr(2'd1, c);
            if (typ == 2'd1) begin
                for (int k = 0; k < 4; k++) host_wr(2'd1, wd[k*16 +: 16]);
            end
        end
    endtask

    // monitor / target engine model: pops and compares at acknowledge time
    initial begin
        forever begin
            @(negedge tclk);
            if (t_req && !t_ack) begin
                for (int k = 0; k < eng_delay; k++) @(negedge tclk);
                launches++;
                if (exp_q.size() == 0) begin
                    chk(0, "R4 unexpected launch", 64'(t_addr), 64'd0);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    chk(t_type == e.typ,   "R2 type",    64'(t_type), 64'(e.typ));
                    chk(t_addr == e.addr,  "R3 address", 64'(t_addr), 64'(e.addr));
                    chk(t_ctl == e.ctl,    "R3 control", 64'(t_ctl),  64'(e.ctl));
                    chk(t_wdata == e.wdata, "R5 wdata",  t_wdata,     e.wdata);
                end
                t_rdata = rd_model(t_addr);
                t_ack = 1;
            end else if (!t_req && t_ack) begin
                t_ack = 0;
            end
        end
    end

    initial begin
        #(200000 * HPER);
        errors++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wr_sel = 2'd3;
        repeat (4) @(negedge hclk);
        hrst_n = 1; trst_n = 1;
        @(negedge hclk);
        // R1
        chk(!busy && !err && !t_req && rsp_data == 0, "R1 reset state",
            {rsp_data[60:0], busy, err, t_req}, 64'd0);

        // R6: info word while idle ignored
        host_wr(2'd1, 16'hDEAD);
        repeat (3) @(negedge hclk);
        chk(!busy && !t_req, "R6 idle info word", 64'(busy), 64'd0);

        // R4/R8: partial read does not launch
        exp_q.push_back('{typ:2'd0, addr:32'hABCD_1234, ctl:16'h000F, wdata:64'd0});
        host_wr(2'd0, 16'd0);
        host_wr(2'd1, 16'h1234);
        host_wr(2'd1, 16'hABCD);
        repeat (12) @(negedge hclk);
        chk(!busy, "R8 busy low while collecting", 64'(busy), 64'd0);
        chk(!t_req, "R4 no launch before count", 64'(t_req), 64'd0);
        @(negedge hclk);
        wr_en = 1; wr_sel = 2'd1; wr_data = 16'h000F;
        @(negedge hclk);
        wr_en = 0; wr_sel = 2'd3;
        chk(busy, "R8 busy after launch", 64'(busy), 64'd1);
        wait_idle("R8 busy clears");
        chk(rsp_data == rd_model(32'hABCD_1234), "R9 read data", rsp_data, rd_model(32'hABCD_1234));

        // write, with R6 info words while busy
        eng_delay = 12;
        send(2'd1, 32'h0040_0010, 16'h00FF, 64'h1122_3344_5566_7788);
        host_wr(2'd1, 16'hFFFF);
        host_wr(2'd1, 16'hEEEE);
        chk(busy, "R6 busy during write", 64'(busy), 64'd1);
        wait_idle("R8 write done");
        chk(rsp_data == rd_model(32'h0040_0010), "R9 write return", rsp_data, rd_model(32'h0040_0010));
        eng_delay = 2;

        // R3: interrupt acknowledge launches on the command alone
        send(2'd2, 32'd0, 16'd0, 64'd0);
        chk(busy, "R3 intack launches at once", 64'(busy), 64'd1);
        wait_idle("R8 intack done");
        chk(rsp_data == rd_model(32'd0), "R9 intack return", rsp_data, rd_model(32'd0));

        // R2: locked read
        send(2'd3, 32'hFFFF_0002, 16'h00F0, 64'd0);
        wait_idle("R8 locked read done");

        // R7: command during collection rejected
        exp_q.push_back('{typ:2'd0, addr:32'h0000_7777, ctl:16'h0001, wdata:64'd0});
        host_wr(2'd0, 16'd0);
        host_wr(2'd1, 16'h7777);
        host_wr(2'd0, 16'd1);
        chk(err, "R7 err on rejected command", 64'(err), 64'd1);
        host_wr(2'd1, 16'h0000);
        host_wr(2'd1, 16'h0001);
        wait_idle("R7 original request completes");
        chk(err, "R7 err sticky", 64'(err), 64'd1);
        host_wr(2'd2, 16'd0);
        chk(!err, "R7 err cleared", 64'(err), 64'd0);

        // same-cycle: command held through whole transaction incl. capture edge
        eng_delay = 8;
        send(2'd0, 32'h1357_9BDF, 16'h0033, 64'd0);
        @(negedge hclk);
        wr_en = 1; wr_sel = 2'd0; wr_data = 16'd1;
        while (busy) @(negedge hclk);
        wr_en = 0; wr_sel = 2'd3;
        chk(err, "R7 err during capture overlap", 64'(err), 64'd1);
        chk(rsp_data == rd_model(32'h1357_9BDF), "R9 capture during reject", rsp_data, rd_model(32'h1357_9BDF));
        repeat (20) @(negedge hclk);
        chk(!busy && !t_req, "R10 no stray launch", 64'(busy), 64'd0);
        chk(exp_q.size() == 0, "R4 all requests launched", 64'(exp_q.size()), 64'd0);
        chk(launches == 6, "R10 launch count", 64'(launches), 64'd6);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule